// File: doc/BRIEF.md
# Integer ALU and Shifter with Instruction Decode

This block is the combinational execute stage of a 32-bit load-store integer core. It receives the raw instruction word together with the two source register values that the register file has already read (the value named by the rs field and the value named by the rt field). A small decoder turns the opcode and function code into an internal operation select. The datapath then produces a result word and a signed-overflow flag in the same cycle. There is no state, clock or reset.

The datapath covers add and subtract in trapping and wrapping forms, four bitwise operations, signed and unsigned less-than compares, an upper-half immediate load, and left, logical-right and arithmetic-right shifts. Immediate forms take their second operand from the low 16 bits of the instruction. That operand is sign-extended or zero-extended depending on the operation. A shift takes its count either from the instruction's shift field or from the low bits of the rs value, and it always shifts the rt value. The trap logic of the core observes the overflow flag and decides what to do with it. Any encoding the block does not recognise yields zero on both outputs.

Top module: `alux_top`

## Requirements
- R1: Bits 31..26 of the instruction are the opcode and bits 5..0 the function code. Opcode 000000 selects a register-register operation by function code: 100000 add-trap, 100001 add-wrap, 100010 sub-trap, 100011 sub-wrap, 100100 AND, 100101 OR, 100110 XOR, 100111 NOR, 101010 signed less-than, 101011 unsigned less-than. The first operand is `src_a_i` and the second is `src_b_i`. Subtraction computes `src_a_i - src_b_i`.
- R2: Immediate opcodes are 001000 add-imm-trap, 001001 add-imm-wrap, 001010 signed less-than-imm, 001011 unsigned less-than-imm, 001100 AND-imm, 001101 OR-imm, 001110 XOR-imm and 001111 upper-load. The immediate is instruction bits 15..0 and the first operand is `src_a_i`.
- R3: `overflow_o` is 1 exactly when add-trap, sub-trap or add-imm-trap overflows as a signed 32-bit operation. The wrapping forms never raise it. The result is the wrapped 32-bit sum or difference in every case.
- R4: AND-imm, OR-imm and XOR-imm zero-extend the immediate. Add-imm and both less-than-imm forms sign-extend it. The unsigned compare uses the sign-extended value read as unsigned.
- R5: Shifts operate on `src_b_i`. Function codes 000000/000100 shift left and fill with zeros. Codes 000010/000110 shift right and fill with zeros. Codes 000011/000111 shift right and fill with copies of bit 31.
- R6: Function codes 000000, 000010 and 000011 take the count (0 to 31) from instruction bits 10..6. Codes 000100, 000110 and 000111 take it from bits 4..0 of `src_a_i`, and bits 31..5 of `src_a_i` have no effect on the result.
- R7: The less-than operations return 1 or 0 in bit 0, with bits 31..1 zero.
- R8: Upper-load returns the immediate in bits 31..16 and zeros in bits 15..0.
- R9: Any opcode or function code not listed in R1, R2 and R5 gives `result_o` = 0 and `overflow_o` = 0.
- R10: AND, OR, XOR and NOR and their immediate forms are bitwise over all 32 bits, and their `overflow_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Raw instruction word |
| src_a_i | input | 32 | Value of the register named by the rs field |
| src_b_i | input | 32 | Value of the register named by the rt field |
| result_o | output | 32 | Operation result |
| overflow_o | output | 1 | Signed overflow on trapping add/subtract |

## Verification
Since the block holds no state, a wrong decode or a wrong operand path shows at the outputs in the same cycle the instruction is applied. Nothing is hidden for a later cycle. A wrong extension choice shows only when the immediate's bit 15 is set. A wrong shift fill shows only when the rt value is negative. A count path that reads the wrong bits shows only when the upper bits of the rs value are non-zero. The directed and random stimulus therefore biases operands toward sign-boundary values and loads the unused upper bits with noise. The overflow flag is compared on every vector, so that a leak of the flag into the wrapping forms is also caught.

// File: rtl/alux_pkg.sv
package alux_pkg;

   typedef enum logic [3:0] {
      K_NONE, K_ADD_T, K_ADD_W, K_SUB_T, K_SUB_W,
      K_AND, K_OR, K_XOR, K_NOR, K_LT_S, K_LT_U,
      K_UPPER, K_SHL, K_SHR_L, K_SHR_A
   } alu_kind_e;

   typedef enum logic [1:0] {B_REG, B_SEXT, B_ZEXT} bsrc_e;

   typedef struct packed {
      alu_kind_e kind;
      bsrc_e     bsrc;
      logic      cnt_reg;
   } alu_ctrl_t;

   localparam logic [5:0] OPC_REG   = 6'b000000;
   localparam logic [5:0] OPC_ADDIT = 6'b001000;
   localparam logic [5:0] OPC_ADDIW = 6'b001001;
   localparam logic [5:0] OPC_LTIS  = 6'b001010;
   localparam logic [5:0] OPC_LTIU  = 6'b001011;
   localparam logic [5:0] OPC_ANDI  = 6'b001100;
   localparam logic [5:0] OPC_ORI   = 6'b001101;
   localparam logic [5:0] OPC_XORI  = 6'b001110;
   localparam logic [5:0] OPC_UPPER = 6'b001111;

endpackage

// File: rtl/alux_decode.sv
module alux_decode
   import alux_pkg::*;
(
   input  logic [5:0] opc_i,
   input  logic [5:0] fn_i,
   output alu_ctrl_t  ctrl_o
);

   always_comb begin
      ctrl_o = '{kind: K_NONE, bsrc: B_REG, cnt_reg: 1'b0};
      unique case (opc_i)
         OPC_REG: begin
            case (fn_i)
               6'b100000: ctrl_o.kind = K_ADD_T;
               6'b100001: ctrl_o.kind = K_ADD_W;
               6'b100010: ctrl_o.kind = K_SUB_T;
               6'b100011: ctrl_o.kind = K_SUB_W;
               6'b100100: ctrl_o.kind = K_AND;
               6'b100101: ctrl_o.kind = K_OR;
               6'b100110: ctrl_o.kind = K_XOR;
               6'b100111: ctrl_o.kind = K_NOR;
               6'b101010: ctrl_o.kind = K_LT_S;
               6'b101011: ctrl_o.kind = K_LT_U;
               6'b000000: ctrl_o.kind = K_SHL;
               6'b000010: ctrl_o.kind = K_SHR_L;
               6'b000011: ctrl_o.kind = K_SHR_A;
               6'b000100: begin ctrl_o.kind = K_SHL;   ctrl_o.cnt_reg = 1'b1; end
               6'b000110: begin ctrl_o.kind = K_SHR_L; ctrl_o.cnt_reg = 1'b1; end
               6'b000111: begin ctrl_o.kind = K_SHR_A; ctrl_o.cnt_reg = 1'b1; end
               default:   ctrl_o.kind = K_NONE;
            endcase
         end
         OPC_ADDIT: begin ctrl_o.kind = K_ADD_T; ctrl_o.bsrc = B_SEXT; end
         OPC_ADDIW: begin ctrl_o.kind = K_ADD_W; ctrl_o.bsrc = B_SEXT; end
         OPC_LTIS:  begin ctrl_o.kind = K_LT_S;  ctrl_o.bsrc = B_SEXT; end
         OPC_LTIU:  begin ctrl_o.kind = K_LT_U;  ctrl_o.bsrc = B_SEXT; end
         OPC_ANDI:  begin ctrl_o.kind = K_AND;   ctrl_o.bsrc = B_ZEXT; end
         OPC_ORI:   begin ctrl_o.kind = K_OR;    ctrl_o.bsrc = B_ZEXT; end
         OPC_XORI:  begin ctrl_o.kind = K_XOR;   ctrl_o.bsrc = B_ZEXT; end
         OPC_UPPER: begin ctrl_o.kind = K_UPPER; ctrl_o.bsrc = B_ZEXT; end
         default:   ctrl_o.kind = K_NONE;
      endcase
   end

endmodule

// File: rtl/alux_adder.sv
module alux_adder #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic            sub_i,
   output logic [XLEN-1:0] sum_o,
   output logic            ovf_o,
   output logic            lt_s_o,
   output logic            lt_u_o
);

   localparam int MSB = XLEN - 1;

   logic [XLEN-1:0] b_eff;
   logic [XLEN:0]   wide;

   always_comb begin
      b_eff  = b_i ^ {XLEN{sub_i}};
      wide   = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub_i};
      sum_o  = wide[MSB:0];
      ovf_o  = (a_i[MSB] == b_eff[MSB]) && (wide[MSB] != a_i[MSB]);
      lt_u_o = ~wide[XLEN];
      lt_s_o = (a_i[MSB] != b_i[MSB]) ? a_i[MSB] : wide[MSB];
   end

endmodule

// File: rtl/alux_shifter.sv
module alux_shifter #(
   parameter int XLEN   = 32,
   parameter bit BARREL = 1'b1,
   localparam int SHW   = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] data_i,
   input  logic [SHW-1:0]  amt_i,
   input  logic            left_i,
   input  logic            arith_i,
   output logic [XLEN-1:0] data_o
);

   generate
      if (BARREL) begin : g_staged
         always_comb begin
            logic [XLEN-1:0] v;
            v = data_i;
            for (int i = 0; i < SHW; i++) begin
               if (amt_i[i]) begin
                  if (left_i)
                     v = v << (1 << i);
                  else if (arith_i)
                     v = XLEN'($signed(v) >>> (1 << i));
                  else
                     v = v >> (1 << i);
               end
            end
            data_o = v;
         end
      end else begin : g_flat
         always_comb begin
            if (left_i)
               data_o = data_i << amt_i;
            else if (arith_i)
               data_o = XLEN'($signed(data_i) >>> amt_i);
            else
               data_o = data_i >> amt_i;
         end
      end
   endgenerate

endmodule

// File: rtl/alux_top.sv
module alux_top
   import alux_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int IMMW   = 16,
   parameter bit BARREL = 1'b1
) (
   input  logic [31:0]     instr_i,
   input  logic [XLEN-1:0] src_a_i,
   input  logic [XLEN-1:0] src_b_i,
   output logic [XLEN-1:0] result_o,
   output logic            overflow_o
);

   localparam int SHW = $clog2(XLEN);
   localparam int EXT = XLEN - IMMW;

   generate
      if ((1 << SHW) != XLEN || XLEN < 2 * IMMW || IMMW != 16) begin : g_bad_cfg
         $error("alux_top: XLEN must be a power of two >= 32 and IMMW must be 16");
      end
   endgenerate

   alu_ctrl_t       ctrl;
   logic [IMMW-1:0] imm;
   logic [XLEN-1:0] opnd_b, sum, shifted;
   logic [SHW-1:0]  cnt;
   logic            sub, add_ovf, lt_s, lt_u;
   logic            unused_fields;

   assign imm           = instr_i[IMMW-1:0];
   assign unused_fields = ^instr_i[25:16];

   alux_decode i_decode (
      .opc_i  (instr_i[31:26]),
      .fn_i   (instr_i[5:0]),
      .ctrl_o (ctrl)
   );

   always_comb begin
      unique case (ctrl.bsrc)
         B_SEXT:  opnd_b = {{EXT{imm[IMMW-1]}}, imm};
         B_ZEXT:  opnd_b = {{EXT{1'b0}}, imm};
         default: opnd_b = src_b_i;
      endcase
      sub = ctrl.kind inside {K_SUB_T, K_SUB_W, K_LT_S, K_LT_U};
      cnt = ctrl.cnt_reg ? src_a_i[SHW-1:0] : SHW'(instr_i[10:6]);
   end

   alux_adder #(.XLEN(XLEN)) i_adder (
      .a_i    (src_a_i),
      .b_i    (opnd_b),
      .sub_i  (sub),
      .sum_o  (sum),
      .ovf_o  (add_ovf),
      .lt_s_o (lt_s),
      .lt_u_o (lt_u)
   );

   alux_shifter #(.XLEN(XLEN), .BARREL(BARREL)) i_shifter (
      .data_i  (src_b_i),
      .amt_i   (cnt),
      .left_i  (ctrl.kind == K_SHL),
      .arith_i (ctrl.kind == K_SHR_A),
      .data_o  (shifted)
   );

   always_comb begin
      overflow_o = 1'b0;
      unique case (ctrl.kind)
         K_ADD_T, K_SUB_T: begin
            result_o   = sum;
            overflow_o = add_ovf;
         end
         K_ADD_W, K_SUB_W:        result_o = sum;
         K_AND:                   result_o = src_a_i & opnd_b;
         K_OR:                    result_o = src_a_i | opnd_b;
         K_XOR:                   result_o = src_a_i ^ opnd_b;
         K_NOR:                   result_o = ~(src_a_i | opnd_b);
         K_LT_S:                  result_o = {{(XLEN-1){1'b0}}, lt_s};
         K_LT_U:                  result_o = {{(XLEN-1){1'b0}}, lt_u};
         K_UPPER:                 result_o = {imm, {EXT{1'b0}}};
         K_SHL, K_SHR_L, K_SHR_A: result_o = shifted;
         default:                 result_o = '0;
      endcase
   end

endmodule

// File: rtl/alux_check.sv
module alux_check #(
   parameter int XLEN = 32
) (
   input logic [31:0]     instr_i,
   input logic [XLEN-1:0] src_a_i,
   input logic [XLEN-1:0] src_b_i,
   input logic [XLEN-1:0] result_o,
   input logic            overflow_o
);

   logic [5:0] opc, fn;
   logic [4:0] shf;
   logic       is_r;
   logic       unused_ck;

   assign opc       = instr_i[31:26];
   assign fn        = instr_i[5:0];
   assign shf       = instr_i[10:6];
   assign is_r      = (opc == 6'b000000);
   assign unused_ck = ^instr_i[25:16] ^ ^src_a_i[XLEN-1:5];

   always_comb begin
      if ((is_r && (fn == 6'b100001 || fn == 6'b100011)) || opc == 6'b001001)
         AST_NO_OVERFLOW: assert (!overflow_o) else $error("wrap form raised overflow"); // R3
      if (overflow_o)
         AST_OVF_SOURCE: assert ((is_r && (fn == 6'b100000 || fn == 6'b100010)) || opc == 6'b001000)
            else $error("overflow from a non-trapping operation"); // R3
      if ((is_r && (fn == 6'b101010 || fn == 6'b101011)) || opc == 6'b001010 || opc == 6'b001011)
         AST_LT_BOOL: assert (result_o[XLEN-1:1] == '0) else $error("compare result not 0/1"); // R7
      if (opc == 6'b001111)
         AST_UPPER_HALF: assert (result_o[15:0] == 16'h0 && result_o[XLEN-1 -: 16] == instr_i[15:0])
            else $error("upper-load placement wrong"); // R8
      if (opc == 6'b001100)
         AST_ZEXT_AND: assert (result_o[XLEN-1:16] == '0) else $error("AND-imm not zero-extended"); // R4
      if (is_r && fn == 6'b000011 && shf != 5'd0)
         AST_SRA_FILL: assert (result_o[XLEN-1] == src_b_i[XLEN-1]) else $error("sign fill wrong"); // R5
      if (is_r && fn == 6'b000010 && shf != 5'd0)
         AST_SRL_FILL: assert (result_o[XLEN-1] == 1'b0) else $error("zero fill wrong"); // R5
      if (is_r && (fn == 6'b000100 || fn == 6'b000110 || fn == 6'b000111) && src_a_i[4:0] == 5'd0)
         AST_VAR_ZERO: assert (result_o == src_b_i) else $error("zero register count changed data"); // R6
   end

endmodule

bind alux_top alux_check #(.XLEN(XLEN)) i_alux_check (
   .instr_i    (instr_i),
   .src_a_i    (src_a_i),
   .src_b_i    (src_b_i),
   .result_o   (result_o),
   .overflow_o (overflow_o)
);

// File: tb/test_alux_top.sv
module test_alux_top;

   logic        clk = 1'b0;
   logic [31:0] instr = '0, a = '0, b = '0;
   logic [31:0] res;
   logic        ovf;
   int          total = 0, bad = 0;
   bit          done = 1'b0;

   always #10ns clk = ~clk;

   alux_top i_alux_top (
      .instr_i    (instr),
      .src_a_i    (a),
      .src_b_i    (b),
      .result_o   (res),
      .overflow_o (ovf)
   );

   function automatic logic [31:0] r_word(input logic [5:0] fn, input logic [4:0] sh);
      return {6'b000000, 5'd3, 5'd4, 5'd2, sh, fn};
   endfunction

   function automatic logic [31:0] i_word(input logic [5:0] opc, input logic [15:0] imm);
      return {opc, 5'd3, 5'd2, imm};
   endfunction

   function automatic void model(input logic [31:0] ins, input logic [31:0] x, input logic [31:0] y,
                                 output logic [31:0] r, output logic v);
      logic [5:0]  opc = ins[31:26];
      logic [5:0]  fn  = ins[5:0];
      logic [31:0] se  = {{16{ins[15]}}, ins[15:0]};
      logic [31:0] ze  = {16'h0, ins[15:0]};
      longint      s;
      r = 32'h0; v = 1'b0;
      if (opc == 6'b000000) begin
         case (fn)
            6'b100000, 6'b100001: begin
               s = longint'($signed(x)) + longint'($signed(y)); r = x + y;
               v = (fn == 6'b100000) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            6'b100010, 6'b100011: begin
               s = longint'($signed(x)) - longint'($signed(y)); r = x - y;
               v = (fn == 6'b100010) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            6'b100100: r = x & y;
            6'b100101: r = x | y;
            6'b100110: r = x ^ y;
            6'b100111: r = ~(x | y);
            6'b101010: r = {31'h0, $signed(x) < $signed(y)};
            6'b101011: r = {31'h0, x < y};
            6'b000000: r = y << ins[10:6];
            6'b000010: r = y >> ins[10:6];
            6'b000011: r = $signed(y) >>> ins[10:6];
            6'b000100: r = y << x[4:0];
            6'b000110: r = y >> x[4:0];
            6'b000111: r = $signed(y) >>> x[4:0];
            default:   r = 32'h0;
         endcase
      end else begin
         case (opc)
            6'b001000, 6'b001001: begin
               s = longint'($signed(x)) + longint'($signed(se)); r = x + se;
               v = (opc == 6'b001000) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            6'b001010: r = {31'h0, $signed(x) < $signed(se)};
            6'b001011: r = {31'h0, x < se};
            6'b001100: r = x & ze;
            6'b001101: r = x | ze;
            6'b001110: r = x ^ ze;
            6'b001111: r = {ins[15:0], 16'h0};
            default:   r = 32'h0;
         endcase
      end
   endfunction

   task automatic run(input logic [31:0] ins, input logic [31:0] x, input logic [31:0] y,
                      input string tag);
      logic [31:0] er;
      logic        ev;
      @(posedge clk);
      instr = ins; a = x; b = y;
      model(ins, x, y, er, ev);
      @(negedge clk);
      total++;
      if (res !== er || ovf !== ev) begin
         bad++;
         $display("FAIL %s instr=%h a=%h b=%h: actual res=%h ovf=%b expected res=%h ovf=%b",
                  tag, ins, x, y, res, ovf, er, ev);
      end
   endtask

   task automatic expect_val(input logic [31:0] ins, input logic [31:0] x, input logic [31:0] y,
                             input logic [31:0] er, input logic ev, input string tag);
      @(posedge clk);
      instr = ins; a = x; b = y;
      @(negedge clk);
      total++;
      if (res !== er || ovf !== ev) begin
         bad++;
         $display("FAIL %s instr=%h: actual res=%h ovf=%b expected res=%h ovf=%b",
                  tag, ins, res, ovf, er, ev);
      end
   endtask

   function automatic logic [31:0] pick_val();
      case ($urandom_range(0, 7))
         0: return 32'h0;
         1: return 32'h7fffffff;
         2: return 32'h80000000;
         3: return 32'hffffffff;
         default: return $urandom();
      endcase
   endfunction

   function automatic logic [31:0] pick_instr();
      int k = $urandom_range(0, 24);
      logic [31:0] w = $urandom();
      logic [5:0] fns [16] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
                               6'h2A, 6'h2B, 6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07};
      if (k < 16) return {6'b000000, w[25:6], fns[k]};
      if (k < 24) return {6'(6'b001000 + 6'(k - 16)), w[25:0]};
      return w;
   endfunction

   initial begin
      #(200000 * 20ns);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4177));
      // idle state: all-zero word is a shift by 0 of zero
      expect_val(32'h0, 32'h0, 32'h0, 32'h0, 1'b0, "R5 idle");
      // R1 register add, word 00641020
      expect_val(32'h00641020, 32'd5, 32'd7, 32'd12, 1'b0, "R1 add");
      expect_val(r_word(6'h22, 0), 32'd3, 32'd10, 32'hfffffff9, 1'b0, "R1 sub order");
      // R3 overflow corners
      expect_val(r_word(6'h20, 0), 32'h7fffffff, 32'h1, 32'h80000000, 1'b1, "R3 add-trap");
      expect_val(r_word(6'h21, 0), 32'h7fffffff, 32'h1, 32'h80000000, 1'b0, "R3 add-wrap");
      expect_val(r_word(6'h22, 0), 32'h80000000, 32'h1, 32'h7fffffff, 1'b1, "R3 sub-trap");
      expect_val(r_word(6'h23, 0), 32'h80000000, 32'h1, 32'h7fffffff, 1'b0, "R3 sub-wrap");
      expect_val(i_word(6'b001000, 16'h0001), 32'h7fffffff, 32'h0, 32'h80000000, 1'b1, "R3 addi-trap");
      // R2 / R4 immediates
      expect_val(i_word(6'b001000, 16'hfffc), 32'h0, 32'h0, 32'hfffffffc, 1'b0, "R4 addi sext");
      expect_val(i_word(6'b001100, 16'h8001), 32'hffffffff, 32'h0, 32'h00008001, 1'b0, "R4 andi zext");
      expect_val(i_word(6'b001101, 16'h8000), 32'h0, 32'h0, 32'h00008000, 1'b0, "R4 ori zext");
      expect_val(i_word(6'b001010, 16'hffff), 32'hfffffffe, 32'h0, 32'h1, 1'b0, "R2 lt-imm signed");
      expect_val(i_word(6'b001011, 16'hffff), 32'd5, 32'h0, 32'h1, 1'b0, "R4 lt-imm unsigned sext");
      // R7 compares
      expect_val(r_word(6'h2A, 0), 32'hffffffff, 32'h1, 32'h1, 1'b0, "R7 signed lt");
      expect_val(r_word(6'h2B, 0), 32'hffffffff, 32'h1, 32'h0, 1'b0, "R7 unsigned lt");
      // R8 upper load
      expect_val(i_word(6'b001111, 16'h1234), 32'hffffffff, 32'h0, 32'h12340000, 1'b0, "R8 upper");
      // R5 / R6 shifts
      expect_val(r_word(6'h03, 5'd2), 32'h0, 32'hfffffff5, 32'hfffffffd, 1'b0, "R5 sra fill");
      expect_val(r_word(6'h02, 5'd2), 32'h0, 32'h00000029, 32'h0000000a, 1'b0, "R5 srl fill");
      expect_val(r_word(6'h02, 5'd31), 32'h0, 32'h80000000, 32'h1, 1'b0, "R5 srl 31");
      expect_val(r_word(6'h00, 5'd4), 32'h0, 32'h8000000f, 32'h000000f0, 1'b0, "R5 sll");
      expect_val(r_word(6'h06, 5'd0), 32'hffffffe2, 32'h00000029, 32'h0000000a, 1'b0, "R6 var upper ignored");
      expect_val(r_word(6'h07, 5'd9), 32'h00000004, 32'h80000000, 32'hf8000000, 1'b0, "R6 var count from reg");
      expect_val(r_word(6'h04, 5'd0), 32'hffffffe0, 32'h12345678, 32'h12345678, 1'b0, "R6 var count zero");
      // R10 bitwise
      expect_val(r_word(6'h27, 0), 32'hf0f00000, 32'h0000f0f0, 32'h0f0f0f0f, 1'b0, "R10 nor");
      expect_val(r_word(6'h26, 0), 32'hffff0000, 32'h0f0f0f0f, 32'hf0f00f0f, 1'b0, "R10 xor");
      expect_val(i_word(6'b001110, 16'hffff), 32'h12345678, 32'h0, 32'h1234a987, 1'b0, "R10 xori");
      // R9 undefined encodings
      expect_val(r_word(6'h01, 5'd3), 32'hffffffff, 32'hffffffff, 32'h0, 1'b0, "R9 bad function");
      expect_val(i_word(6'b100011, 16'h0004), 32'h7fffffff, 32'h7fffffff, 32'h0, 1'b0, "R9 bad opcode");
      // mixed random, all requirements (R1/R2/R3/R4/R5/R6/R7/R8/R9/R10)
      for (int n = 0; n < 4000; n++)
         run(pick_instr(), pick_val(), pick_val(), "random");
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule